// File: doc/BRIEF.md
# Reuse-Distance Histogram Profiler

This block watches one thread's line-address stream into a set-associative cache with true LRU replacement. It keeps its own recency order for every set and looks up each access against it. A hit at recency position i adds one to histogram bin i. An access whose line is not present adds one to a separate miss bin. The stored order is then updated exactly as an LRU cache would update it.

A cycle counter advances on a tick input, so software can divide any bin by elapsed cycles to get a rate. Because the histogram is kept per recency position, the miss count for any smaller associativity A' is the miss bin plus every bin above A'. This is more than a plain hit/miss total can give.

All counters are read through a single indexed port with one cycle of latency. A synchronous clear restarts a profiling interval.

Top module: `reuse_profiler`

## Requirements
- R1: The line address is the byte address with its low OFF_W (6) bits removed. The set is the low SET_W (4) bits of the line address, and the tag is the remaining upper bits. Two bytes of the same line map to the same entry, and equal tags in different sets never match.
- R2: Position 1 is the most recently used line of a set. A valid access that hits the line at position i (1..WAYS) increments the bin read at index i-1.
- R3: A valid access whose line is absent, or present only in invalid entries, increments the miss bin read at index WAYS (8).
- R4: Each valid access increments exactly one bin. A cycle with acc_valid_i low changes no bin and leaves the recency state untouched.
- R5: Replacement is true LRU. A hit moves the line to position 1 and shifts the more recent lines down by one. A miss inserts the line at position 1 and drops the line at position WAYS.
- R6: The cycle counter, read at index WAYS+1 (9), increments in each cycle with tick_i high and holds otherwise.
- R7: Every counter saturates at its all-ones value instead of wrapping.
- R8: While clr_i is high, a clock edge zeroes all counters and invalidates every recency entry. Clear takes priority over an access or tick in the same cycle.
- R9: rd_data_o shows the counter selected by rd_idx_i at the previous clock edge. Indices above WAYS+1 read zero.
- R10: After reset, all counters read zero and all recency entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of counters and recency state |
| acc_valid_i | input | 1 | An access is present this cycle |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| tick_i | input | 1 | Advance the cycle counter |
| rd_idx_i | input | IDX_W | Counter select: 0..WAYS-1 position bins, WAYS miss bin, WAYS+1 cycle count |
| rd_data_o | output | CNT_W | Selected counter, registered |

## Verification
The assertions assume the recency rows are written only through the block's own update path. Under that assumption a tag appears at most once per set, which is why a lookup matches at most one way. They also assume the inputs are stable around the clock edge. The stimulus draws a small pool of tags over a few sets, so that every recency position, evictions and misses all occur often. Inputs are driven only on the falling edge. A second instance with 4-bit counters runs on the same stimulus, so saturation is reached and checked without impractically long runs.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_HIT  = 2'd1,
    ACC_MISS = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/rp_lru_stack.sv
module rp_lru_stack
  import rp_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int SETS  = 16,
  parameter int TAG_W = 22,
  localparam int SET_W = $clog2(SETS),
  localparam int POS_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             acc_valid_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  output acc_kind_e        kind_o,
  output logic [POS_W-1:0] pos_o
);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  logic [WAYS-1:0]  match;
  logic             hit;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] shift_lim;
  logic [TAG_W-1:0] row_tag_d [WAYS];
  logic [WAYS-1:0]  row_vld_d;
  logic             wr_en;

  // Lookup against the addressed row
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      match[w] = vld_q[set_i][w] && (tag_q[set_i][w] == tag_i);
    end
  end

  assign hit = |match;

  always_comb begin
    pos = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) pos = POS_W'(w);
    end
  end

  // Recency update: entries above the hit (or the whole row on a miss) slide down
  assign shift_lim = hit ? pos : POS_W'(WAYS - 1);

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (w == 0) begin
        row_tag_d[w] = tag_i;
        row_vld_d[w] = 1'b1;
      end else if (POS_W'(w) <= shift_lim) begin
        row_tag_d[w] = tag_q[set_i][w-1];
        row_vld_d[w] = vld_q[set_i][w-1];
      end else begin
        row_tag_d[w] = tag_q[set_i][w];
        row_vld_d[w] = vld_q[set_i][w];
      end
    end
  end

  assign wr_en = acc_valid_i && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (clr_i) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[set_i] <= row_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[set_i] <= row_tag_d;
    end
  end

  always_comb begin
    if (!acc_valid_i) kind_o = ACC_IDLE;
    else if (hit)     kind_o = ACC_HIT;
    else              kind_o = ACC_MISS;
  end

  assign pos_o = pos;

  // R2: a tag lives at most once in a row, so at most one way matches
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i |-> $onehot0(match));

  // R5: the accessed line sits valid at position 1 after the update
  a_r5_mru_update: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !clr_i) |=>
      (vld_q[$past(set_i)][0] && (tag_q[$past(set_i)][0] == $past(tag_i))));

endmodule

// File: rtl/rp_sat_ctr.sv
module rp_sat_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] q_o
);

  localparam logic [CNT_W-1:0] MAX_V = '1;

  logic [CNT_W-1:0] q_q;
  logic [CNT_W-1:0] q_d;
  logic             en;

  always_comb begin
    if (clr_i)                        q_d = '0;
    else if (inc_i && (q_q != MAX_V)) q_d = q_q + 1'b1;
    else                              q_d = q_q;
  end

  assign en = clr_i || inc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= '0;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;

  // R4: outside a clear, a counter moves by zero or one per cycle
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((q_q == $past(q_q)) || (q_q == $past(q_q) + 1'b1)));

  // R7: a full counter stays full
  a_r7_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && (q_q == MAX_V)) |=> (q_q == MAX_V));

  // R8: clear lands as zero on the next edge
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (q_q == '0));

endmodule

// File: rtl/rp_hist_bank.sv
module rp_hist_bank
  import rp_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int CNT_W = 32,
  localparam int POS_W = $clog2(WAYS),
  localparam int NCNT  = WAYS + 2,
  localparam int IDX_W = $clog2(NCNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  acc_kind_e        kind_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             tick_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o
);

  localparam int MISS_IDX = WAYS;
  localparam int CYC_IDX  = WAYS + 1;

  logic [NCNT-1:0]  inc;
  logic [CNT_W-1:0] cnt [NCNT];
  logic [CNT_W-1:0] rd_d;
  logic [CNT_W-1:0] rd_q;

  generate
    for (genvar c = 0; c < NCNT; c++) begin : g_ctr
      if (c < WAYS) begin : g_pos
        assign inc[c] = (kind_i == ACC_HIT) && (pos_i == POS_W'(c));
      end else if (c == MISS_IDX) begin : g_miss
        assign inc[c] = (kind_i == ACC_MISS);
      end else begin : g_cyc
        assign inc[c] = tick_i;
      end
      rp_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .inc_i (inc[c]),
        .q_o   (cnt[c])
      );
    end
  endgenerate

  always_comb begin
    rd_d = '0;
    for (int c = 0; c < NCNT; c++) begin
      if (rd_idx_i == IDX_W'(c)) rd_d = cnt[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  // R4: an access raises at most one histogram or miss bin
  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc[NCNT-2:0]));

  // R6: without a tick the cycle count holds
  a_r6_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt[CYC_IDX]));

endmodule

// File: rtl/reuse_profiler.sv
module reuse_profiler
  import rp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int WAYS   = 8,
  parameter int SETS   = 16,
  parameter int CNT_W  = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TAG_W  = LINE_W - SET_W,
  localparam int POS_W  = $clog2(WAYS),
  localparam int IDX_W  = $clog2(WAYS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              tick_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [CNT_W-1:0]  rd_data_o
);

  logic [LINE_W-1:0] line;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag;
  acc_kind_e         kind;
  logic [POS_W-1:0]  pos;
  logic              unused_offset;

  assign line          = acc_addr_i[ADDR_W-1:OFF_W];
  assign set_idx       = line[SET_W-1:0];
  assign tag           = line[LINE_W-1:SET_W];
  assign unused_offset = ^acc_addr_i[OFF_W-1:0];

  rp_lru_stack #(
    .WAYS  (WAYS),
    .SETS  (SETS),
    .TAG_W (TAG_W)
  ) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .acc_valid_i (acc_valid_i),
    .set_i       (set_idx),
    .tag_i       (tag),
    .kind_o      (kind),
    .pos_o       (pos)
  );

  rp_hist_bank #(
    .WAYS  (WAYS),
    .CNT_W (CNT_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .kind_i    (kind),
    .pos_i     (pos),
    .tick_i    (tick_i),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: tb/reuse_profiler_tb.sv
module reuse_profiler_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WAYS   = 8;
  localparam int SETS   = 16;
  localparam int NCNT   = WAYS + 2;
  localparam int IDX_W  = 4;
  localparam int NAR_W  = 4;
  localparam longint NAR_MAX = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        tick;
  logic [IDX_W-1:0] rd_idx;
  logic [31:0] rd_wide;
  logic [NAR_W-1:0] rd_nar;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint exp_cnt [NCNT];
  int     m_tag [SETS][WAYS];
  bit     m_vld [SETS][WAYS];

  always #(CLK_PERIOD/2) clk = ~clk;

  reuse_profiler u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .acc_valid_i(acc_valid),
    .acc_addr_i(acc_addr), .tick_i(tick), .rd_idx_i(rd_idx), .rd_data_o(rd_wide)
  );

  reuse_profiler #(.CNT_W(NAR_W)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .acc_valid_i(acc_valid),
    .acc_addr_i(acc_addr), .tick_i(tick), .rd_idx_i(rd_idx), .rd_data_o(rd_nar)
  );

  function automatic logic [31:0] mk_addr(int tg, int st, int off);
    return (32'(tg) << 10) | (32'(st) << 6) | 32'(off & 63);
  endfunction

  function automatic longint nar_of(longint v);
    return (v > NAR_MAX) ? NAR_MAX : v;
  endfunction

  task automatic model_clear();
    for (int c = 0; c < NCNT; c++) exp_cnt[c] = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0;
        m_tag[s][w] = 0;
      end
  endtask

  task automatic model_access(logic [31:0] a);
    int st = int'(a[9:6]);
    int tg = int'(a[31:10]);
    int p = -1;
    int lim;
    for (int w = 0; w < WAYS; w++)
      if (p < 0 && m_vld[st][w] && m_tag[st][w] == tg) p = w;
    if (p >= 0) begin
      exp_cnt[p]++;
      lim = p;
    end else begin
      exp_cnt[WAYS]++;
      lim = WAYS - 1;
    end
    for (int w = lim; w > 0; w--) begin
      m_tag[st][w] = m_tag[st][w-1];
      m_vld[st][w] = m_vld[st][w-1];
    end
    m_tag[st][0] = tg;
    m_vld[st][0] = 1;
  endtask

  task automatic drive(bit v, logic [31:0] a, bit tk);
    @(negedge clk);
    acc_valid = v;
    acc_addr  = a;
    tick      = tk;
    if (v) model_access(a);
    if (tk) exp_cnt[WAYS+1]++;
  endtask

  task automatic read_check(int idx, longint ev, string req);
    @(negedge clk);
    acc_valid = 0;
    tick      = 0;
    rd_idx    = IDX_W'(idx);
    @(negedge clk);
    checks++;
    if (longint'(rd_wide) != ev) begin
      errors++;
      $display("FAIL %s idx %0d wide actual %0d expected %0d", req, idx, rd_wide, ev);
    end
    checks++;
    if (longint'(rd_nar) != nar_of(ev)) begin
      errors++;
      $display("FAIL %s idx %0d narrow actual %0d expected %0d", req, idx, rd_nar, nar_of(ev));
    end
  endtask

  task automatic check_all(string req);
    for (int c = 0; c < NCNT; c++) read_check(c, exp_cnt[c], req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 0; clr = 0; acc_valid = 0; acc_addr = '0; tick = 0; rd_idx = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: reset state
    check_all("R10");
    for (int i = NCNT; i < 16; i++) read_check(i, 0, "R9");

    // R2 / R3: A B C A in set 3, A found at position 3
    drive(1, mk_addr(1, 3, 0), 1);
    drive(1, mk_addr(2, 3, 5), 0);
    drive(1, mk_addr(3, 3, 9), 1);
    drive(1, mk_addr(1, 3, 63), 0);
    read_check(2, 1, "R2");
    read_check(WAYS, 3, "R3");

    // R1: other byte of the same line hits position 1; same tag, other set misses
    drive(1, mk_addr(1, 3, 17), 0);
    read_check(0, 1, "R1");
    drive(1, mk_addr(1, 4, 17), 0);
    read_check(WAYS, 4, "R1");

    // R5: nine distinct lines in set 5 evict the oldest
    for (int t = 10; t < 19; t++) drive(1, mk_addr(t, 5, t), 1);
    drive(1, mk_addr(11, 5, 0), 0);
    drive(1, mk_addr(10, 5, 0), 0);
    drive(1, mk_addr(18, 5, 0), 0);
    check_all("R5");

    // R4: idle cycles with an address present change nothing
    for (int k = 0; k < 6; k++) drive(0, mk_addr(1, 3, 0), 0);
    check_all("R4");

    // R6: ticks alone advance only the cycle count
    for (int k = 0; k < 7; k++) drive(0, '0, 1);
    read_check(WAYS + 1, exp_cnt[WAYS+1], "R6");

    // R9: output holds the previously selected counter until the next edge
    read_check(WAYS, exp_cnt[WAYS], "R9");
    @(negedge clk);
    rd_idx = 4'd2;
    #1;
    checks++;
    if (longint'(rd_wide) != exp_cnt[WAYS]) begin
      errors++;
      $display("FAIL R9 latency actual %0d expected %0d", rd_wide, exp_cnt[WAYS]);
    end

    // R7: narrow counters saturate on repeated misses and ticks
    for (int k = 0; k < 20; k++) drive(1, mk_addr(100 + k, 7, 0), 1);
    check_all("R7");

    // R8: clear with access and tick in the same cycle
    @(negedge clk);
    clr = 1; acc_valid = 1; acc_addr = mk_addr(1, 3, 0); tick = 1;
    model_clear();
    @(negedge clk);
    clr = 0; acc_valid = 0; tick = 0;
    check_all("R8");
    drive(1, mk_addr(1, 3, 0), 0);
    read_check(WAYS, 1, "R8");
    read_check(0, 0, "R8");

    // Random phase: small tag pool over few sets
    for (int k = 0; k < 3000; k++) begin
      bit v  = ($urandom % 8) != 0;
      bit tk = ($urandom % 2) != 0;
      drive(v, mk_addr(int'($urandom % 12), int'($urandom % 3), int'($urandom % 64)), tk);
    end
    check_all("R2");
    for (int i = NCNT; i < 16; i++) read_check(i, 0, "R9");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule